// File: doc/BRIEF.md
# Sequence-Serviced Watchdog Timer

This block is a watchdog timer for a system-on-chip. Software arms it through a small 16-bit register port. After that the block counts down a timeout that is programmed in half-second units. Only an exact two-word service handshake restarts the count. If software stops servicing it, the block either requests a system reset or pulses an open-drain style watchdog line low for one cycle. Which of the two happens is chosen by a control bit. Software can also request a reset directly. A separate low-power input can freeze the count.

The enable bit can only be set, never cleared. The suspend bit can be written once after reset. The cause of the most recent reset, timeout or software, is held in a status register that only the power-on reset clears. The block also contains a power-down counter. It is armed out of reset and, on expiry, drops the watchdog line for one cycle, unless software switches it off first.

The register port has no back-pressure. Every access with `bus_valid` high completes in the cycle it is presented. Read data is returned in that same cycle. The half-second time base arrives as a one-cycle `tick_en` strobe.

Top module: `seq_watchdog`

## Requirements
- R1: After reset, reads return: control register (offset 0x0) 0x0010, service register (0x2) 0x0000, miscellaneous register (0x8) 0x0001, and any unmapped offset 0x0000. After power-on reset, the status register (0x4) reads 0x0000.
- R2: The control register layout is: bits 15:8 hold the timeout `T`, bit 4 is the software-reset bit (active low), bit 3 is the mode select, bit 2 is the enable, and bit 0 is the suspend bit. Writing the enable bit as 1 loads the counter with T+1 ticks. The timeout fires on the (T+1)-th `tick_en` strobe after that load. Strobes that arrive while the enable bit is clear have no effect.
- R3: A timeout with mode select 0 drives `sys_rst_req` high for exactly RST_LEN cycles.
- R4: Once set, the enable bit cannot be cleared by any write, and counting continues.
- R5: Bit 0 is taken from the first control write after reset and is fixed from then on. While bit 0 is 1 and `lowpower` is high, strobes do not count.
- R6: The counter is reloaded with T+1, using the current T, when a service-register write of 0x5555 is followed by a service-register write of 0xAAAA. A repeated 0x5555 keeps the handshake armed.
- R7: A service write of any other value breaks the handshake, and a lone 0xAAAA does nothing. Writes to other registers between the two words do not break it.
- R8: Rewriting T while the counter is running reads back at once. The new T takes effect only at the next reload.
- R9: Every control write with bit 4 at 0 restarts a `sys_rst_req` pulse of RST_LEN cycles, beginning in the next cycle, so back-to-back writes lengthen the pulse. Bit 4 always reads as 1.
- R10: Status bit 1 is set and bit 0 cleared by a timeout reset; status bit 0 is set and bit 1 cleared by a software reset. The status survives `rst_n`, ignores writes, and is cleared only by `por_n`.
- R11: A timeout with mode select 1 drives `wdog_line_n` low for exactly one cycle. It raises no `sys_rst_req` and leaves the status unchanged.
- R12: Out of reset, the power-down counter drives `wdog_line_n` low for one cycle on the PD_TICKS-th strobe, and only once. A miscellaneous write with bit 0 at 0 disables it; a later write of 1 does not re-enable it.
- R13: The register port accepts one access in every cycle with no wait states.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low system reset (all state except cause) |
| por_n | input | 1 | Asynchronous active-low power-on reset (reset cause) |
| tick_en | input | 1 | One-cycle half-second strobe |
| lowpower | input | 1 | Low-power state indication |
| bus_valid | input | 1 | Register access present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle of a read |
| sys_rst_req | output | 1 | System reset request pulse |
| wdog_line_n | output | 1 | Active-low watchdog line |

## Verification
A wrong count value or a wrong reload shows up only as a reset edge on the wrong strobe. The sweep over every small timeout therefore counts reset edges strobe by strobe, so an off-by-one is caught within one tick. A handshake checker that is stuck armed, or that re-arms wrongly, shows up as a reset that arrives early or a reset that never comes. The tests place the failing handshakes so that each of these errors moves the reset by at least one strobe. Lost write-once protection and a corrupted reset cause are seen in the very next register read. Pulse-length faults appear within RST_LEN cycles.

// File: rtl/seqwdt_pkg.sv
package seqwdt_pkg;
  localparam int DW   = 16;
  localparam int AW   = 4;
  localparam int WT_W = 8;

  localparam logic [AW-1:0] OFS_CTRL = 4'h0;
  localparam logic [AW-1:0] OFS_SVC  = 4'h2;
  localparam logic [AW-1:0] OFS_STAT = 4'h4;
  localparam logic [AW-1:0] OFS_MISC = 4'h8;

  localparam logic [DW-1:0] KEY_ARM  = 16'h5555;
  localparam logic [DW-1:0] KEY_FIRE = 16'hAAAA;

  typedef struct packed {
    logic [WT_W-1:0] wt;
    logic            sel_line;
    logic            en;
    logic            zst;
  } ctrl_t;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_SW   = 2'b01,
    CAUSE_TO   = 2'b10
  } cause_e;
endpackage

// File: rtl/seqwdt_regs.sv
module seqwdt_regs
  import seqwdt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            por_n,
  input  logic            bus_valid,
  input  logic            bus_write,
  input  logic [AW-1:0]   bus_addr,
  input  logic [WT_W-1:0] in_wt,
  input  logic            in_swr,
  input  logic            in_sel,
  input  logic            in_en,
  input  logic            in_bit0,
  input  logic            to_rst,
  output ctrl_t           ctrl,
  output logic            start,
  output logic            sw_req,
  output logic            svc_wr,
  output logic            pd_en,
  output logic [DW-1:0]   bus_rdata
);
  logic   wr_hit, wr_ctrl, wr_misc, zst_lock;
  cause_e cause;

  assign wr_hit  = bus_valid && bus_write;
  assign wr_ctrl = wr_hit && (bus_addr == OFS_CTRL);
  assign wr_misc = wr_hit && (bus_addr == OFS_MISC);
  assign svc_wr  = wr_hit && (bus_addr == OFS_SVC);
  assign start   = wr_ctrl && in_en && !ctrl.en;
  assign sw_req  = wr_ctrl && !in_swr;

  // control register with sticky enable and write-once suspend
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      zst_lock <= 1'b0;
    end else if (wr_ctrl) begin
      ctrl.wt       <= in_wt;
      ctrl.sel_line <= in_sel;
      if (in_en) ctrl.en <= 1'b1;
      if (!zst_lock) begin
        ctrl.zst <= in_bit0;
        zst_lock <= 1'b1;
      end
    end
  end

  // power-down counter enable: can only be turned off
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pd_en <= 1'b1;
    else if (wr_misc && !in_bit0) pd_en <= 1'b0;
  end

  // reset cause, kept across system reset
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) cause <= CAUSE_NONE;
    else if (sw_req) cause <= CAUSE_SW;
    else if (to_rst) cause <= CAUSE_TO;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_valid && !bus_write) begin
      case (bus_addr)
        OFS_CTRL: bus_rdata = {ctrl.wt, 3'b000, 1'b1, ctrl.sel_line, ctrl.en, 1'b0, ctrl.zst};
        OFS_STAT: bus_rdata = {{(DW-2){1'b0}}, cause};
        OFS_MISC: bus_rdata = {{(DW-1){1'b0}}, pd_en};
        default:  bus_rdata = '0;
      endcase
    end
  end

  AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.en |=> ctrl.en); // R4
  AST_ZST_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    zst_lock |=> $stable(ctrl.zst)); // R5
  AST_SW_CAUSE: assert property (@(posedge clk) disable iff (!por_n)
    sw_req |=> (cause == CAUSE_SW)); // R10
endmodule

// File: rtl/seqwdt_svc.sv
module seqwdt_svc
  import seqwdt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          svc_wr,
  input  logic [DW-1:0] wdata,
  output logic          fire
);
  logic armed;

  assign fire = svc_wr && armed && (wdata == KEY_FIRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else if (svc_wr) armed <= (wdata == KEY_ARM);
  end

  AST_FIRE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !armed); // R6
endmodule

// File: rtl/seqwdt_cnt.sv
module seqwdt_cnt #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          hold,
  input  logic          tick,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic [CW-1:0] ref_val,
  output logic          expire
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (load) begin
        cnt <= load_val;
      end else if (run && tick && !hold) begin
        if (cnt <= CW'(1)) begin
          expire <= 1'b1;
          cnt    <= ref_val;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  AST_CNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt != '0)); // R2
  AST_EXPIRE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> $past(run)); // R2
endmodule

// File: rtl/seqwdt_pdc.sv
module seqwdt_pdc #(
  parameter int TICKS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic enable,
  output logic pulse
);
  localparam int PW = $clog2(TICKS + 1);
  logic [PW-1:0] cnt;
  logic          done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      done  <= 1'b0;
      pulse <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (enable && !done && tick) begin
        if (cnt == PW'(TICKS - 1)) begin
          pulse <= 1'b1;
          done  <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_PD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse); // R12
endmodule

// File: rtl/seqwdt_outs.sv
module seqwdt_outs #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_req,
  input  logic to_rst,
  input  logic to_line,
  input  logic pd_pulse,
  output logic sys_rst_req,
  output logic line_n
);
  localparam int RW = $clog2(LEN + 1);
  logic [RW-1:0] rcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt   <= '0;
      line_n <= 1'b1;
    end else begin
      if (sw_req || to_rst) rcnt <= RW'(LEN);
      else if (rcnt != '0) rcnt <= rcnt - 1'b1;
      line_n <= !(to_line || pd_pulse);
    end
  end

  assign sys_rst_req = (rcnt != '0);

  AST_REQ_START: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_req || to_rst) |=> sys_rst_req); // R9
  AST_LINE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    !line_n |-> $past(to_line || pd_pulse)); // R11
endmodule

// File: rtl/seq_watchdog.sv
module seq_watchdog
  import seqwdt_pkg::*;
#(
  parameter int RST_LEN  = 4,
  parameter int PD_TICKS = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          por_n,
  input  logic          tick_en,
  input  logic          lowpower,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [3:0]    bus_addr,
  input  logic [15:0]   bus_wdata,
  output logic [15:0]   bus_rdata,
  output logic          sys_rst_req,
  output logic          wdog_line_n
);
  localparam int CW = WT_W + 1;

  ctrl_t          ctrl;
  logic           start, sw_req, svc_wr, pd_en, fire, expire, pd_pulse;
  logic           to_rst, to_line, load;
  logic [CW-1:0]  start_val, ref_val, load_val;

  seqwdt_regs u_regs (
    .clk(clk), .rst_n(rst_n), .por_n(por_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .in_wt(bus_wdata[15:8]), .in_swr(bus_wdata[4]), .in_sel(bus_wdata[3]),
    .in_en(bus_wdata[2]), .in_bit0(bus_wdata[0]),
    .to_rst(to_rst), .ctrl(ctrl), .start(start), .sw_req(sw_req),
    .svc_wr(svc_wr), .pd_en(pd_en), .bus_rdata(bus_rdata)
  );

  seqwdt_svc u_svc (
    .clk(clk), .rst_n(rst_n), .svc_wr(svc_wr), .wdata(bus_wdata), .fire(fire)
  );

  assign start_val = CW'(bus_wdata[15:8]) + CW'(1);
  assign ref_val   = CW'(ctrl.wt) + CW'(1);
  assign load      = start || fire;
  assign load_val  = start ? start_val : ref_val;

  seqwdt_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(ctrl.en), .hold(ctrl.zst && lowpower),
    .tick(tick_en), .load(load), .load_val(load_val), .ref_val(ref_val),
    .expire(expire)
  );

  assign to_rst  = expire && !ctrl.sel_line;
  assign to_line = expire && ctrl.sel_line;

  seqwdt_pdc #(.TICKS(PD_TICKS)) u_pdc (
    .clk(clk), .rst_n(rst_n), .tick(tick_en), .enable(pd_en), .pulse(pd_pulse)
  );

  seqwdt_outs #(.LEN(RST_LEN)) u_outs (
    .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .to_rst(to_rst),
    .to_line(to_line), .pd_pulse(pd_pulse),
    .sys_rst_req(sys_rst_req), .line_n(wdog_line_n)
  );
endmodule

// File: tb/seq_watchdog_test.sv
`timescale 1ns/1ps
module seq_watchdog_test;
  localparam int RLEN = 4;
  localparam int PDT  = 32;
  localparam logic [3:0] A_CTRL = 4'h0, A_SVC = 4'h2, A_STAT = 4'h4, A_MISC = 4'h8;

  logic clk = 0, rst_n = 0, por_n = 0, tick_en = 0, lowpower = 0;
  logic bus_valid = 0, bus_write = 0;
  logic [3:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic sys_rst_req, wdog_line_n;

  int errors = 0, checks = 0;
  int rises = 0, hi_cyc = 0, line_low = 0;
  logic prev_req = 0;

  seq_watchdog #(.RST_LEN(RLEN), .PD_TICKS(PDT)) uut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .tick_en(tick_en), .lowpower(lowpower),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sys_rst_req(sys_rst_req), .wdog_line_n(wdog_line_n)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (sys_rst_req) hi_cyc++;
    if (sys_rst_req && !prev_req) rises++;
    prev_req = sys_rst_req;
    if (!wdog_line_n) line_low++;
  end

  function automatic logic [15:0] cv(input logic [7:0] wt, input logic sel,
                                     input logic en, input logic zst);
    return {wt, 3'b000, 1'b1, sel, en, 1'b0, zst};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    #2;
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_valid = 0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1;
      @(negedge clk); tick_en = 0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sysrst();
    @(negedge clk); rst_n = 0; lowpower = 0;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic svc_pair();
    wr(A_SVC, 16'h5555);
    wr(A_SVC, 16'hAAAA);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL R13 watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int r0, h0, l0, st;
    settle(3);
    por_n = 1; rst_n = 1;
    settle(2);

    // R1 reset values
    rd(A_CTRL, d); chk("R1 ctrl reset", d, 16'h0010);
    rd(A_SVC,  d); chk("R1 service reads zero", d, 0);
    rd(A_MISC, d); chk("R1 misc reset", d, 1);
    rd(A_STAT, d); chk("R1 status after power-on", d, 0);
    rd(4'h6,   d); chk("R1 unmapped offset", d, 0);

    // R2/R3/R10/R13 sweep over small timeouts
    for (int w = 0; w < 8; w++) begin
      sysrst();
      if (w > 0) begin rd(A_STAT, d); chk("R10 status survives rst_n", d, 2); end
      wr(A_MISC, 16'h0000);
      r0 = rises;
      tick(3);
      chk("R2 strobes ignored before enable", rises, r0);
      wr(A_CTRL, cv(w[7:0], 0, 1, 0));
      if (w > 0) tick(w);
      chk("R2 no timeout before T+1 strobes", rises, r0);
      h0 = hi_cyc;
      tick(1); settle(8);
      chk("R2 timeout on strobe T+1", rises, r0 + 1);
      chk("R3 reset pulse length", hi_cyc - h0, RLEN);
      rd(A_STAT, d); chk("R10 timeout cause", d, 2);
    end

    // R9 software reset, single and repeated
    sysrst(); wr(A_MISC, 0);
    r0 = rises; h0 = hi_cyc;
    wr(A_CTRL, 16'h0000); settle(8);
    chk("R9 single software reset edge", rises, r0 + 1);
    chk("R9 single software reset length", hi_cyc - h0, RLEN);
    rd(A_STAT, d); chk("R10 software cause", d, 1);
    rd(A_CTRL, d); chk("R9 bit4 reads one", d, 16'h0010);
    r0 = rises; h0 = hi_cyc;
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = A_CTRL; bus_wdata = 16'h0000;
    repeat (3) @(negedge clk);
    bus_valid = 0; bus_write = 0;
    settle(8);
    chk("R9 repeated writes one long pulse", rises, r0 + 1);
    chk("R9 repeated writes extend pulse", hi_cyc - h0, RLEN + 2);
    wr(A_STAT, 16'h0002);
    rd(A_STAT, d); chk("R10 status ignores writes", d, 1);

    // R10 power-on reset clears cause
    @(negedge clk); por_n = 0;
    @(negedge clk); por_n = 1;
    rd(A_STAT, d); chk("R10 cleared by power-on", d, 0);

    // R4 enable cannot be cleared
    sysrst(); wr(A_MISC, 0);
    wr(A_CTRL, cv(3, 0, 1, 0));
    wr(A_CTRL, cv(3, 0, 0, 0));
    rd(A_CTRL, d); chk("R4 enable reads set", d, cv(3, 0, 1, 0));
    r0 = rises;
    tick(3); chk("R4 still counting, not yet", rises, r0);
    tick(1); chk("R4 still times out", rises, r0 + 1);

    // R5 suspend bit set first
    sysrst(); wr(A_MISC, 0);
    wr(A_CTRL, cv(1, 0, 1, 1));
    lowpower = 1; r0 = rises;
    tick(5); chk("R5 frozen in low power", rises, r0);
    wr(A_CTRL, cv(1, 0, 1, 0));
    rd(A_CTRL, d); chk("R5 suspend bit locked at one", d, cv(1, 0, 1, 1));
    tick(3); chk("R5 still frozen", rises, r0);
    lowpower = 0;
    tick(1); chk("R5 resumes counting", rises, r0);
    tick(1); chk("R5 timeout after resume", rises, r0 + 1);

    // R5 suspend bit clear first
    sysrst(); wr(A_MISC, 0);
    wr(A_CTRL, cv(1, 0, 1, 0));
    wr(A_CTRL, cv(1, 0, 1, 1));
    rd(A_CTRL, d); chk("R5 suspend bit locked at zero", d, cv(1, 0, 1, 0));
    lowpower = 1; r0 = rises;
    tick(2); chk("R5 counts when suspend clear", rises, r0 + 1);
    lowpower = 0;

    // R6 valid handshake
    sysrst(); wr(A_MISC, 0);
    wr(A_CTRL, cv(5, 0, 1, 0)); r0 = rises;
    tick(4); svc_pair();
    tick(5); chk("R6 handshake reloads", rises, r0);
    tick(1); chk("R6 timeout after reload", rises, r0 + 1);

    sysrst(); wr(A_MISC, 0);
    wr(A_CTRL, cv(5, 0, 1, 0)); r0 = rises;
    tick(4); wr(A_SVC, 16'h5555); svc_pair();
    tick(5); chk("R6 repeated arm word still valid", rises, r0);

    // R7 broken handshakes
    sysrst(); wr(A_MISC, 0);
    wr(A_CTRL, cv(5, 0, 1, 0)); r0 = rises;
    tick(4); wr(A_SVC, 16'h5555); wr(A_SVC, 16'h1234); wr(A_SVC, 16'hAAAA);
    tick(1); chk("R7 broken sequence, not yet", rises, r0);
    tick(1); chk("R7 broken sequence no reload", rises, r0 + 1);

    sysrst(); wr(A_MISC, 0);
    wr(A_CTRL, cv(5, 0, 1, 0)); r0 = rises;
    tick(4); wr(A_SVC, 16'hAAAA);
    tick(2); chk("R7 lone second word ignored", rises, r0 + 1);

    sysrst(); wr(A_MISC, 0);
    wr(A_CTRL, cv(5, 0, 1, 0)); r0 = rises;
    tick(4); wr(A_SVC, 16'h5555); wr(A_CTRL, cv(5, 0, 1, 0)); wr(A_SVC, 16'hAAAA);
    tick(5); chk("R7 other register write keeps arm", rises, r0);

    // R8 timeout rewrite while running
    sysrst(); wr(A_MISC, 0);
    wr(A_CTRL, cv(3, 0, 1, 0)); r0 = rises;
    tick(2); wr(A_CTRL, cv(9, 0, 1, 0));
    rd(A_CTRL, d); chk("R8 new timeout reads back", d, cv(9, 0, 1, 0));
    tick(1); chk("R8 old timeout still pending", rises, r0);
    tick(1); chk("R8 old timeout fires", rises, r0 + 1);
    svc_pair();
    tick(9); chk("R8 new timeout after reload", rises, r0 + 1);
    tick(1); chk("R8 new timeout fires", rises, r0 + 2);

    // R11 line mode
    sysrst(); wr(A_MISC, 0);
    rd(A_STAT, d); st = d;
    wr(A_CTRL, cv(2, 1, 1, 0));
    r0 = rises; l0 = line_low;
    tick(3); settle(4);
    chk("R11 line low one cycle", line_low - l0, 1);
    chk("R11 no reset request", rises, r0);
    rd(A_STAT, d); chk("R11 status unchanged", d, st);

    // R12 power-down counter
    sysrst(); l0 = line_low;
    tick(PDT - 1); chk("R12 not expired early", line_low, l0);
    tick(1); chk("R12 expiry pulse", line_low, l0 + 1);
    tick(8); chk("R12 only once", line_low, l0 + 1);
    rd(A_MISC, d); chk("R12 misc still enabled", d, 1);
    sysrst(); wr(A_MISC, 0);
    rd(A_MISC, d); chk("R12 disabled by zero", d, 0);
    wr(A_MISC, 1);
    rd(A_MISC, d); chk("R12 not re-enabled", d, 0);
    l0 = line_low;
    tick(PDT + 4); chk("R12 no pulse when disabled", line_low, l0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule